// File: doc/BRIEF.md
# Supply Supervisor with Filtered Reset

This block watches the flags from an analog supply monitor and turns them into two things the rest of the chip needs. The first is an early-warning status bit. Software picks one of two warning thresholds: the lower one, nominally 2.9 V, or the upper one, nominally 3.3 V. The status bit then shows whether the supply sits below the chosen threshold. The second is a system reset, driven by a separate brownout comparator at nominally 2.3 V.

A brownout must be seen on ten consecutive clock cycles before reset fires. This filters short dips on the supply. Once reset fires, it is held for 512 cycles after the last qualifying brownout cycle. While reset is active, the supervisor returns its own threshold selection to the power-up value.

All comparator flags are asynchronous digital inputs, and each one passes through a two-flop synchroniser. There is no data stream: every pin is a plain control or status signal, with no handshake.

Top module: `supply_supervisor`

## Requirements
- R1: After `rst_n` is released, `sys_rst` is 0, `status_word` is all zeros, and the lower threshold is selected.
- R2: A cycle with `lvl_wr_en`=1 loads `lvl_wr_hi` into the threshold select (0 = lower, 1 = upper) at that clock edge. `status_word[0]` reads back the current select, and it holds its value when no write occurs.
- R3: `status_word[15]` equals `cmp_below_hi` when the upper threshold is selected, and `cmp_below_lo` otherwise. A comparator change sampled at one edge appears after the second edge; a select change appears after the edge that loads it.
- R4: `status_word[14:1]` always read 0.
- R5: If `cmp_brownout` is sampled high on 10 consecutive rising edges, `sys_rst` rises at the second edge after the tenth sample.
- R6: Any edge that samples `cmp_brownout` low clears the qualification. Nine high samples, one low sample and then nine more high samples give no reset.
- R7: `sys_rst` stays high for exactly 512 cycles after the last qualifying brownout cycle. When `cmp_brownout` is first sampled low at edge d1, `sys_rst` is still 1 after edge d1+512 and is 0 after edge d1+513.
- R8: While the brownout stays qualified, the hold count restarts every cycle, so `sys_rst` stays high for as long as the brownout lasts, well past 512 cycles.
- R9: While `sys_rst` is high, the threshold select is forced to the lower level and writes to it are ignored. `status_word[0]` reads 0 from the edge after `sys_rst` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low power-on reset of the supervisor itself |
| lvl_wr_en | input | 1 | Write strobe for the warning-threshold select |
| lvl_wr_hi | input | 1 | Value written: 1 selects the upper threshold, 0 the lower |
| cmp_below_lo | input | 1 | Asynchronous flag: supply is below the lower warning threshold |
| cmp_below_hi | input | 1 | Asynchronous flag: supply is below the upper warning threshold |
| cmp_brownout | input | 1 | Asynchronous flag: supply is below the brownout level |
| sys_rst | output | 1 | Active-high system reset |
| status_word | output | 16 | Bit 15: low-voltage warning; bit 0: threshold select readback; other bits 0 |

## Verification
The assertions assume that every comparator flag is sampled only after the two-flop synchroniser, so a flag counts only once the synchronised copy has changed. They also assume that `rst_n` is asserted before any flag activity. The stimulus changes flags and write strobes only on falling edges, which keeps each input stable around the rising edge that samples it. Brownout pulses are held for whole cycles, so the counts of consecutive samples are exact. The threshold write is issued both outside and during a reset, to exercise the override.

// File: rtl/supsv_pkg.sv
package supsv_pkg;
  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } lvl_sel_e;

  localparam int STATUS_W     = 16;
  localparam int LV_FLAG_BIT  = 15;
  localparam int LVL_READ_BIT = 0;
endpackage

// File: rtl/supsv_sync.sv
module supsv_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/supsv_level.sv
module supsv_level
  import supsv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     force_low,
  input  logic     wr_en,
  input  logic     wr_hi,
  input  logic     below_lo_s,
  input  logic     below_hi_s,
  output lvl_sel_e sel_q,
  output logic     warn_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_q <= LVL_LOW;
    else if (force_low) sel_q <= LVL_LOW;
    else if (wr_en)     sel_q <= wr_hi ? LVL_HIGH : LVL_LOW;
  end

  always_comb begin
    unique case (sel_q)
      LVL_HIGH: warn_flag = below_hi_s;
      default:  warn_flag = below_lo_s;
    endcase
  end
endmodule

// File: rtl/supsv_qual.sv
module supsv_qual #(
  parameter int QUAL_CYCLES = 10,
  localparam int CW = $clog2(QUAL_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flag_s,
  output logic [CW-1:0] run_cnt,
  output logic          qualified
);
  localparam logic [CW-1:0] CNT_LAST = CW'(QUAL_CYCLES - 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(QUAL_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_cnt <= '0;
    else if (!flag_s)          run_cnt <= '0;
    else if (run_cnt != CNT_SAT) run_cnt <= run_cnt + 1'b1;
  end

  assign qualified = flag_s && (run_cnt >= CNT_LAST);
endmodule

// File: rtl/supsv_stretch.sv
module supsv_stretch #(
  parameter int HOLD_CYCLES = 512,
  localparam int HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic rst_out
);
  localparam logic [HW-1:0] RELOAD = HW'(HOLD_CYCLES - 1);
  logic [HW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_out  <= 1'b0;
      remain_q <= '0;
    end else if (trigger) begin
      rst_out  <= 1'b1;
      remain_q <= RELOAD;
    end else if (rst_out) begin
      if (remain_q == '0) rst_out  <= 1'b0;
      else                remain_q <= remain_q - 1'b1;
    end
  end
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supsv_pkg::*;
#(
  parameter int QUAL_CYCLES = 10,
  parameter int HOLD_CYCLES = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lvl_wr_en,
  input  logic                lvl_wr_hi,
  input  logic                cmp_below_lo,
  input  logic                cmp_below_hi,
  input  logic                cmp_brownout,
  output logic                sys_rst,
  output logic [STATUS_W-1:0] status_word
);
  localparam int QCW = $clog2(QUAL_CYCLES + 1);

  logic [2:0]     flags_s;
  logic           below_lo_s, below_hi_s, bo_sync;
  lvl_sel_e       sel_q;
  logic           warn_flag;
  logic [QCW-1:0] qual_cnt;
  logic           qualified;

  supsv_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({cmp_brownout, cmp_below_hi, cmp_below_lo}),
    .q_sync  (flags_s)
  );

  assign below_lo_s = flags_s[0];
  assign below_hi_s = flags_s[1];
  assign bo_sync    = flags_s[2];

  supsv_level u_level (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_low  (sys_rst),
    .wr_en      (lvl_wr_en),
    .wr_hi      (lvl_wr_hi),
    .below_lo_s (below_lo_s),
    .below_hi_s (below_hi_s),
    .sel_q      (sel_q),
    .warn_flag  (warn_flag)
  );

  supsv_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_s    (bo_sync),
    .run_cnt   (qual_cnt),
    .qualified (qualified)
  );

  supsv_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigger (qualified),
    .rst_out (sys_rst)
  );

  always_comb begin
    status_word               = '0;
    status_word[LV_FLAG_BIT]  = warn_flag;
    status_word[LVL_READ_BIT] = (sel_q == LVL_HIGH);
  end
endmodule

// File: rtl/supsv_checker.sv
module supsv_checker #(
  parameter int QUAL_CYCLES = 10,
  parameter int HOLD_CYCLES = 512,
  localparam int QCW = $clog2(QUAL_CYCLES + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           lvl_wr_en,
  input logic           sys_rst,
  input logic [15:0]    status_word,
  input logic           bo_sync,
  input logic [QCW-1:0] qual_cnt
);
  logic [31:0] high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       high_run <= '0;
    else if (sys_rst) high_run <= high_run + 1;
    else              high_run <= '0;
  end

  // R5
  rst_rise_after_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> ($past(bo_sync) && ($past(qual_cnt) == QCW'(QUAL_CYCLES - 1))));

  // R6
  low_sample_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bo_sync |=> (qual_cnt == '0));

  // R7
  hold_min_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> (high_run >= HOLD_CYCLES));

  // R8
  qualified_keeps_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_sync && (qual_cnt >= QCW'(QUAL_CYCLES - 1))) |=> sys_rst);

  // R9
  rst_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !status_word[0]);

  // R2
  select_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_wr_en && !sys_rst) |=> $stable(status_word[0]));

  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[14:1] == '0);
endmodule

bind supply_supervisor supsv_checker #(
  .QUAL_CYCLES (QUAL_CYCLES),
  .HOLD_CYCLES (HOLD_CYCLES)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .lvl_wr_en   (lvl_wr_en),
  .sys_rst     (sys_rst),
  .status_word (status_word),
  .bo_sync     (bo_sync),
  .qual_cnt    (qual_cnt)
);

// File: tb/supply_supervisor_tb_top.sv
module supply_supervisor_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 8;
  // each entry: {select_hi, below_lo, below_hi, expected_warn}
  localparam logic [3:0] VECS [NVEC] = '{
    4'b0000, 4'b0101, 4'b0010, 4'b0111,
    4'b1000, 4'b1100, 4'b1011, 4'b1111
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lvl_wr_en = 1'b0, lvl_wr_hi = 1'b0;
  logic cmp_below_lo = 1'b0, cmp_below_hi = 1'b0, cmp_brownout = 1'b0;
  logic sys_rst;
  logic [15:0] status_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  supply_supervisor dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lvl_wr_en    (lvl_wr_en),
    .lvl_wr_hi    (lvl_wr_hi),
    .cmp_below_lo (cmp_below_lo),
    .cmp_below_hi (cmp_below_hi),
    .cmp_brownout (cmp_brownout),
    .sys_rst      (sys_rst),
    .status_word  (status_word)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_sel(input logic hi);
    lvl_wr_en = 1'b1;
    lvl_wr_hi = hi;
    step(1);
    lvl_wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    check("R1 sys_rst", 16'(sys_rst), 16'd0);
    check("R1 status", status_word, 16'h0000);

    // R2 R3 R4 table walk
    for (int i = 0; i < NVEC; i++) begin
      cmp_below_lo = VECS[i][2];
      cmp_below_hi = VECS[i][1];
      write_sel(VECS[i][3]);
      step(1);
      check("R3 warn", 16'(status_word[15]), 16'(VECS[i][0]));
      check("R2 readback", 16'(status_word[0]), 16'(VECS[i][3]));
      check("R4 reserved", 16'(status_word[14:1]), 16'd0);
    end

    // R3 latency: lower level, flag rises
    write_sel(1'b0);
    cmp_below_lo = 1'b0;
    step(3);
    cmp_below_lo = 1'b1;
    step(1);
    check("R3 after one edge", 16'(status_word[15]), 16'd0);
    step(1);
    check("R3 after two edges", 16'(status_word[15]), 16'd1);
    cmp_below_lo = 1'b0;
    step(3);

    // R6: nine high, one low, nine high
    cmp_brownout = 1'b1;
    step(9);
    cmp_brownout = 1'b0;
    step(1);
    cmp_brownout = 1'b1;
    step(9);
    cmp_brownout = 1'b0;
    step(4);
    check("R6 no reset after split run", 16'(sys_rst), 16'd0);

    // R5 exact trip edge, R7 exact hold
    cmp_brownout = 1'b1;
    step(11);
    check("R5 not yet", 16'(sys_rst), 16'd0);
    step(1);
    check("R5 fires", 16'(sys_rst), 16'd1);
    cmp_brownout = 1'b0;
    step(513);
    check("R7 still held", 16'(sys_rst), 16'd1);
    step(1);
    check("R7 released", 16'(sys_rst), 16'd0);

    // R8 and R9
    write_sel(1'b1);
    check("R9 pre select", 16'(status_word[0]), 16'd1);
    cmp_brownout = 1'b1;
    step(12);
    check("R8 fires", 16'(sys_rst), 16'd1);
    step(1);
    check("R9 forced low", 16'(status_word[0]), 16'd0);
    write_sel(1'b1);
    check("R9 write ignored", 16'(status_word[0]), 16'd0);
    step(600);
    check("R8 held during long brownout", 16'(sys_rst), 16'd1);
    cmp_brownout = 1'b0;
    step(514);
    check("R8 released", 16'(sys_rst), 16'd0);
    check("R9 stays low after release", 16'(status_word[0]), 16'd0);
    write_sel(1'b1);
    check("R2 write after reset", 16'(status_word[0]), 16'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule